// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Write Modes

This block is a synchronous memory with two ports, A and B, on a single clock. Each port has its own enable, write enable, address, write data and registered read data. Both ports can read or write any word in the same cycle. The depth and the word width are parameters. The depth must be at least two words and need not be a power of two. The address is `$clog2(DEPTH)` bits wide, so some address values can point past the last word.

A parameter fixes the write mode of each port at elaboration, and the two ports are set independently. The mode decides what a port's read output shows after a write on that same port:

- **Write-first:** the output shows the new data.
- **Read-first:** the output shows the word that was overwritten.
- **No-change:** the output keeps its previous value.

A write to an address at or past the depth is discarded, so stored words cannot be corrupted by a bad address. A read from such an address returns an undefined value. Reset clears both read outputs and leaves the stored words alone.

Top module: `dpram_wm`

## Requirements
- R1: With the enable high and the write enable low, the port's read output shows the stored word at the in-range address one clock edge later.
- R2: With the enable low, the port's read output keeps its value and the write enable and write data are ignored, so no stored word changes.
- R3: A port in write-first mode (encoding 0) shows its own write data on the read output one edge after a write.
- R4: A port in read-first mode (encoding 1) shows, one edge after an in-range write, the word held at that address before the write.
- R5: A port in no-change mode (encoding 2) keeps its read output unchanged across a write on that port.
- R6: A write to an address at or above DEPTH changes no stored word on either port.
- R7: When both ports write the same in-range address in the same cycle, port A's data is stored.
- R8: A read on one port of the address that the other port writes in the same cycle returns the old word.
- R9: While reset is active, both read outputs go to zero, and stored words survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low reset of the read outputs |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | $clog2(DEPTH) | Port A word address |
| a_wdata | input | WIDTH | Port A write data |
| a_rdata | output | WIDTH | Port A registered read data |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | $clog2(DEPTH) | Port B word address |
| b_wdata | input | WIDTH | Port B write data |
| b_rdata | output | WIDTH | Port B registered read data |

## Verification
The bench runs three instances side by side, so each mode is seen on both port A and port B. All three take the same sequence of concurrent writes, plain reads, idle cycles and enable-low writes. A write that overwrites a known word is what separates the modes: write-first shows the new value, read-first shows the replaced value and no-change shows whatever was read before. Other patterns isolate the remaining behaviour:
- A same-address write on both ports shows whether port A really has priority.
- A read against the other port's write at the same address shows whether cross-port reads see old data.
- A fill of every word, then bursts of writes at the unused addresses, then a full readback on both ports shows whether an out-of-range write leaks into any word.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    // Per-port write behaviour, fixed at elaboration
    typedef enum logic [1:0] {
        WM_WRITE_FIRST = 2'd0,
        WM_READ_FIRST  = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_e;

    localparam int NUM_PORTS = 2;

endpackage

// File: rtl/dpram_store.sv
module dpram_store #(
    parameter int DEPTH = 12,
    parameter int WIDTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int NP    = dpram_pkg::NUM_PORTS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NP-1:0]             wr_en,
    input  logic [NP-1:0][AW-1:0]     wr_addr,
    input  logic [NP-1:0][WIDTH-1:0]  wr_data,
    input  logic [NP-1:0][AW-1:0]     rd_addr,
    output logic [NP-1:0][WIDTH-1:0]  rd_word
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
    } store_t;

    store_t        st_d, st_q;
    logic [NP-1:0] wr_ok;

    // Drop any write whose address lies past the last word
    always_comb begin
        for (int p = 0; p < NP; p++) begin
            wr_ok[p] = wr_en[p] && (32'(wr_addr[p]) < DEPTH);
        end
    end

    // Apply the highest port first so that port 0 (A) lands last and wins
    always_comb begin
        st_d = st_q;
        for (int p = NP - 1; p >= 0; p--) begin
            if (wr_ok[p]) begin
                st_d.mem[wr_addr[p]] = wr_data[p];
            end
        end
    end

    // Reads see the stored words as they were before this edge
    always_comb begin
        for (int p = 0; p < NP; p++) begin
            if (32'(rd_addr[p]) < DEPTH) begin
                rd_word[p] = st_q.mem[rd_addr[p]];
            end else begin
                rd_word[p] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R6
    oor_write_keeps_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en != '0) && (wr_ok == '0)) |=> $stable(st_q.mem));

    // R7
    collide_a_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok[0] && wr_ok[1] && (wr_addr[0] == wr_addr[1]))
        |=> (st_q.mem[$past(wr_addr[0])] == $past(wr_data[0])));

    // R7
    a_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok[0] |=> (st_q.mem[$past(wr_addr[0])] == $past(wr_data[0])));

endmodule

// File: rtl/dpram_port.sv
module dpram_port #(
    parameter int               WIDTH = 16,
    parameter dpram_pkg::wmode_e MODE = dpram_pkg::WM_WRITE_FIRST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] mem_word,
    output logic [WIDTH-1:0] dout
);

    import dpram_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] dout;
    } port_t;

    port_t port_d, port_q;

    always_comb begin
        port_d = port_q;
        if (en) begin
            if (!we) begin
                port_d.dout = mem_word;
            end else if (MODE == WM_WRITE_FIRST) begin
                port_d.dout = wdata;
            end else if (MODE == WM_READ_FIRST) begin
                port_d.dout = mem_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    assign dout = port_q.dout;

    // R1
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !we) |=> (dout == $past(mem_word)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(dout));

    generate
        if (MODE == WM_WRITE_FIRST) begin : g_wf
            // R3
            wf_shows_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (en && we) |=> (dout == $past(wdata)));
        end else if (MODE == WM_READ_FIRST) begin : g_rf
            // R4
            rf_shows_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (en && we) |=> (dout == $past(mem_word)));
        end else begin : g_nc
            // R5
            nc_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (en && we) |=> $stable(dout));
        end
    endgenerate

endmodule

// File: rtl/dpram_wm.sv
module dpram_wm #(
    parameter int                DEPTH  = 12,
    parameter int                WIDTH  = 16,
    parameter dpram_pkg::wmode_e MODE_A = dpram_pkg::WM_WRITE_FIRST,
    parameter dpram_pkg::wmode_e MODE_B = dpram_pkg::WM_READ_FIRST,
    localparam int               AW     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_en,
    input  logic             a_we,
    input  logic [AW-1:0]    a_addr,
    input  logic [WIDTH-1:0] a_wdata,
    output logic [WIDTH-1:0] a_rdata,
    input  logic             b_en,
    input  logic             b_we,
    input  logic [AW-1:0]    b_addr,
    input  logic [WIDTH-1:0] b_wdata,
    output logic [WIDTH-1:0] b_rdata
);

    import dpram_pkg::*;

    localparam int NP = NUM_PORTS;

    logic [NP-1:0]             en_v, we_v;
    logic [NP-1:0][AW-1:0]     addr_v;
    logic [NP-1:0][WIDTH-1:0]  wdata_v, word_v, rdata_v;

    assign en_v    = {b_en, a_en};
    assign we_v    = {b_we, a_we};
    assign addr_v  = {b_addr, a_addr};
    assign wdata_v = {b_wdata, a_wdata};

    dpram_store #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH),
        .AW    (AW),
        .NP    (NP)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (en_v & we_v),
        .wr_addr (addr_v),
        .wr_data (wdata_v),
        .rd_addr (addr_v),
        .rd_word (word_v)
    );

    generate
        for (genvar p = 0; p < NP; p++) begin : g_port
            localparam wmode_e PMODE = (p == 0) ? MODE_A : MODE_B;
            dpram_port #(
                .WIDTH (WIDTH),
                .MODE  (PMODE)
            ) u_port (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (en_v[p]),
                .we       (we_v[p]),
                .wdata    (wdata_v[p]),
                .mem_word (word_v[p]),
                .dout     (rdata_v[p])
            );
        end
    endgenerate

    assign a_rdata = rdata_v[0];
    assign b_rdata = rdata_v[1];

endmodule

// File: tb/sim_dpram_wm.sv
module sim_dpram_wm;

    import dpram_pkg::*;

    localparam int DEPTH = 12;
    localparam int WIDTH = 16;
    localparam int AW    = $clog2(DEPTH);
    localparam int NI    = 3;
    localparam int VW    = 2 * (2 + AW + WIDTH);

    // Modes per instance: u0 (WF,RF), u1 (NC,WF), u2 (RF,NC)
    localparam wmode_e MA [NI] = '{WM_WRITE_FIRST, WM_NO_CHANGE, WM_READ_FIRST};
    localparam wmode_e MB [NI] = '{WM_READ_FIRST, WM_WRITE_FIRST, WM_NO_CHANGE};

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic             rst_n;
    logic             a_en, a_we, b_en, b_we;
    logic [AW-1:0]    a_addr, b_addr;
    logic [WIDTH-1:0] a_wdata, b_wdata;
    logic [WIDTH-1:0] rd_a [NI];
    logic [WIDTH-1:0] rd_b [NI];

    dpram_wm #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MODE_A(WM_WRITE_FIRST), .MODE_B(WM_READ_FIRST)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(rd_a[0]),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(rd_b[0]));

    dpram_wm #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MODE_A(WM_NO_CHANGE), .MODE_B(WM_WRITE_FIRST)) u1 (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(rd_a[1]),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(rd_b[1]));

    dpram_wm #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MODE_A(WM_READ_FIRST), .MODE_B(WM_NO_CHANGE)) u2 (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(rd_a[2]),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(rd_b[2]));

    function automatic logic [VW-1:0] mk(bit ea, bit wa, int aa, int da,
                                         bit eb, bit wb, int ab, int db);
        return {ea, wa, AW'(aa), WIDTH'(da), eb, wb, AW'(ab), WIDTH'(db)};
    endfunction

    localparam int NV = 18;
    localparam logic [VW-1:0] VEC [NV] = '{
        mk(1,1, 0,'h1111, 1,1, 1,'h2222),
        mk(1,1, 2,'h3333, 1,1,11,'hBBBB),
        mk(1,1, 3,'h0303, 1,0, 0,0),
        mk(1,0, 1,0,      1,0, 2,0),
        mk(1,1, 1,'h4444, 1,0, 2,0),
        mk(1,1, 4,'h4040, 1,1, 6,'h6060),
        mk(0,1, 4,'hAAAA, 0,1, 6,'hCCCC),      // enable low with write enable high
        mk(1,1,12,'hDEAD, 1,1,15,'hBEEF),      // out-of-range writes
        mk(1,0,11,0,      1,0, 1,0),
        mk(1,1, 5,'h5555, 1,1, 5,'h6666),      // same-address collision
        mk(1,0, 5,0,      1,0, 5,0),
        mk(1,1, 3,'h7777, 1,0, 3,0),           // cross-port read of A's write
        mk(1,0, 3,0,      1,1, 3,'h9999),      // cross-port read of B's write
        mk(1,0, 3,0,      1,0, 0,0),
        mk(1,0,14,0,      1,1, 7,'h0707),
        mk(1,1,13,'h1313, 1,0, 7,0),
        mk(1,0, 7,0,      1,0,11,0),
        mk(1,0, 4,0,      1,0, 6,0)
    };

    logic [WIDTH-1:0] ref_mem [DEPTH];
    bit               ref_w   [DEPTH];
    logic [WIDTH-1:0] exp_a [NI];
    logic [WIDTH-1:0] exp_b [NI];
    bit               val_a [NI];
    bit               val_b [NI];

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    task automatic chk(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Next expected output of one port: {valid, value}
    function automatic logic [WIDTH:0] port_model(wmode_e m, logic en, logic we,
            logic [AW-1:0] addr, logic [WIDTH-1:0] wd, logic [WIDTH-1:0] pe, bit pv);
        bit               ok;
        logic [WIDTH-1:0] old;
        ok  = (int'(addr) < DEPTH) && ref_w[int'(addr) % DEPTH];
        old = ok ? ref_mem[int'(addr) % DEPTH] : '0;
        if (!en)                     return {pv, pe};
        if (!we)                     return {ok, old};
        if (m == WM_WRITE_FIRST)     return {1'b1, wd};
        if (m == WM_READ_FIRST)      return {ok, old};
        return {pv, pe};
    endfunction

    function automatic string tag_for(wmode_e m, logic en, logic we, logic [AW-1:0] addr,
                                      logic oen, logic owe, logic [AW-1:0] oaddr);
        if (!en) return "R2";
        if (we) begin
            if (m == WM_WRITE_FIRST) return "R3";
            if (m == WM_READ_FIRST)  return "R4";
            return "R5";
        end
        if (oen && owe && (oaddr == addr)) return "R8";
        return "R1";
    endfunction

    task automatic run_cycle(input logic [VW-1:0] v, input string force_tag);
        logic [WIDTH:0] r;
        string          ta, tb;
        @(negedge clk);
        {a_en, a_we, a_addr, a_wdata, b_en, b_we, b_addr, b_wdata} = v;
        for (int i = 0; i < NI; i++) begin
            r = port_model(MA[i], a_en, a_we, a_addr, a_wdata, exp_a[i], val_a[i]);
            {val_a[i], exp_a[i]} = r;
            r = port_model(MB[i], b_en, b_we, b_addr, b_wdata, exp_b[i], val_b[i]);
            {val_b[i], exp_b[i]} = r;
        end
        // Reference store: B first, then A so that A wins a collision
        if (b_en && b_we && int'(b_addr) < DEPTH) begin
            ref_mem[b_addr] = b_wdata; ref_w[b_addr] = 1'b1;
        end
        if (a_en && a_we && int'(a_addr) < DEPTH) begin
            ref_mem[a_addr] = a_wdata; ref_w[a_addr] = 1'b1;
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < NI; i++) begin
            ta = (force_tag != "") ? force_tag : tag_for(MA[i], a_en, a_we, a_addr, b_en, b_we, b_addr);
            tb = (force_tag != "") ? force_tag : tag_for(MB[i], b_en, b_we, b_addr, a_en, a_we, a_addr);
            if (a_en && a_we && b_en && b_we && a_addr == b_addr && force_tag == "") begin
                ta = "R7"; tb = "R7";
            end
            if (val_a[i]) chk(ta, rd_a[i], exp_a[i]);
            if (val_b[i]) chk(tb, rd_b[i], exp_b[i]);
        end
    endtask

    task automatic check_reset_state();
        for (int i = 0; i < NI; i++) begin
            chk("R9", rd_a[i], '0);
            chk("R9", rd_b[i], '0);
            exp_a[i] = '0; exp_b[i] = '0;
            val_a[i] = 1'b1; val_b[i] = 1'b1;
        end
    endtask

    initial begin
        for (int k = 0; k < DEPTH; k++) begin
            ref_mem[k] = '0; ref_w[k] = 1'b0;
        end
        rst_n = 1'b0;
        {a_en, a_we, a_addr, a_wdata, b_en, b_we, b_addr, b_wdata} = '0;
        repeat (3) @(posedge clk);
        #1;
        check_reset_state();   // R9 outputs cleared
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R1..R8 across the three mode pairings
        for (int k = 0; k < NV; k++) begin
            run_cycle(VEC[k], "");
        end

        // R6: fill every word, hammer the unused addresses, read everything back
        for (int k = 0; k < DEPTH; k++) begin
            run_cycle(mk(1,1,k,'hA000 + k, 0,0,0,0), "");
        end
        for (int k = DEPTH; k < (1 << AW); k++) begin
            run_cycle(mk(1,1,k,'h5A00 + k, 1,1,(1 << AW) - 1 - (k - DEPTH),'hC300 + k), "R6");
        end
        for (int k = 0; k < DEPTH; k++) begin
            run_cycle(mk(1,0,k,0, 1,0,DEPTH - 1 - k,0), "R6");
        end

        // R9: reset mid-run clears outputs but keeps stored words
        @(negedge clk);
        rst_n = 1'b0;
        {a_en, b_en} = 2'b00;
        @(posedge clk);
        #1;
        check_reset_state();
        @(negedge clk);
        rst_n = 1'b1;
        run_cycle(mk(1,0,2,0, 1,0,9,0), "R9");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule